// File: doc/BRIEF.md
# Address-Triggered Operand Register File

This block holds the architectural register state used by an execute stage: a bank of address registers, a bank of index registers and a bank of wide operand registers. Writing an address register can start a memory transfer on its own, with no separate load or store instruction. A write to a load-type address register fetches the word at the written address into the operand register with the same number. A write to a store-type address register sends that operand register's value to the written address. The zero address register has no side effect.

The execute stage reaches the block through two write ports and one combinational read port. Both write ports share one ready signal. The block drives a request channel toward central memory and takes back a response channel. Only one memory transaction is in flight at a time. Any operand register that is waiting for load data is marked busy, and a read of that register stalls until the data arrives.

The request channel uses valid/ready. Once `mem_req_valid` is high, the address, direction and write data hold steady until `mem_req_ready` is sampled high at a clock edge. The write ports are accepted at a clock edge when `wrN_valid` and `wr_ready` are both high. `wr_ready` drops only when a transaction is still in progress and a presented write would start another. Writes that start no transfer are never held back. The response channel has no back-pressure: `mem_rsp_valid` is a one-cycle pulse.

Top module: `addr_op_regfile`

## Requirements
- R1: After reset every register reads as zero, `wr_ready` is 1, `mem_req_valid` is 0 and `rd_stall` is 0.
- R2: Kind encoding on write and read ports is 0 = address bank, 1 = index bank, 2 = operand bank, 3 = none (reads zero). Address and index registers keep only `wr_data[17:0]` and read back zero-extended to 60 bits; operand registers keep all 60 bits.
- R3: Index register 0 always reads as zero; writes to it have no effect.
- R4: A write to address register 0 stores the value and issues no memory request.
- R5: A write to address register 1 to 5 issues a read request (`mem_req_write` = 0) at `wr_data[17:0]`, and the response data is stored in the operand register with the same index.
- R6: A write to address register 6 or 7 issues a write request (`mem_req_write` = 1) at `wr_data[17:0]`. The write data is the same-index operand register's value in the cycle the address write is accepted; a later write to that operand register does not change it.
- R7: While a load into an operand register is pending, a read of that register raises `rd_stall`. From the cycle after the response, the register reads the returned data with no stall.
- R8: A transaction is in progress from acceptance until request handshake (store) or response (load). During that time `wr_ready` is 0 while any write port presents a write to address register 1 to 7, and 1 otherwise.
- R9: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays valid with unchanged address, direction and data.
- R10: When both write ports write the same register in one cycle, the value from port 1 is kept.
- R11: `mem_req_valid` rises in the cycle after the triggering address write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr0_valid | input | 1 | Write port 0 valid |
| wr0_kind | input | 2 | Write port 0 bank select |
| wr0_idx | input | 3 | Write port 0 register index |
| wr0_data | input | 60 | Write port 0 data |
| wr1_valid | input | 1 | Write port 1 valid (wins on collision) |
| wr1_kind | input | 2 | Write port 1 bank select |
| wr1_idx | input | 3 | Write port 1 register index |
| wr1_data | input | 60 | Write port 1 data |
| wr_ready | output | 1 | Both write ports accepted this cycle |
| rd_en | input | 1 | Read request (qualifies stall) |
| rd_kind | input | 2 | Read bank select |
| rd_idx | input | 3 | Read register index |
| rd_data | output | 60 | Read data, zero-extended for 18-bit banks |
| rd_stall | output | 1 | Read target has a pending load |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = store, 0 = load |
| mem_req_addr | output | 18 | Word address |
| mem_req_wdata | output | 60 | Store data |
| mem_rsp_valid | input | 1 | Load data pulse |
| mem_rsp_data | input | 60 | Load data |

## Verification
The assertions assume memory answers only the load it is currently serving. `mem_rsp_valid` may pulse only after that load's request handshake and before the next request. They also assume the two write ports never name two different transfer-starting address registers in the same cycle. The bench meets the first rule with a memory model that tracks one request and replies a fixed number of cycles after accepting it. It meets the second by driving at most one transfer-starting write per cycle. It holds `mem_req_ready` low for several cycles, so the back-pressure and busy-stall windows are exercised with a request really waiting.

// File: rtl/arf_pkg.sv
package arf_pkg;
  typedef enum logic [1:0] {
    BANK_A    = 2'd0,
    BANK_B    = 2'd1,
    BANK_X    = 2'd2,
    BANK_NONE = 2'd3
  } bank_e;

  typedef enum logic [1:0] {
    SL_IDLE = 2'd0,
    SL_REQ  = 2'd1,
    SL_WAIT = 2'd2
  } slot_e;
endpackage

// File: rtl/arf_bank.sv
module arf_bank #(
  parameter int W          = 18,
  parameter int N          = 8,
  parameter bit ZERO_FIRST = 1'b0,
  localparam int IW        = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we_hi,
  input  logic [IW-1:0]  idx_hi,
  input  logic [W-1:0]   d_hi,
  input  logic           we_lo,
  input  logic [IW-1:0]  idx_lo,
  input  logic [W-1:0]   d_lo,
  input  logic           we_fill,
  input  logic [IW-1:0]  idx_fill,
  input  logic [W-1:0]   d_fill,
  output logic [N*W-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    if (ZERO_FIRST && g == 0) begin : g_zero
      assign q[g*W +: W] = '0;
    end else begin : g_reg
      logic [W-1:0] r;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          r <= '0;
        end else if (we_hi && idx_hi == IW'(g)) begin
          r <= d_hi;
        end else if (we_lo && idx_lo == IW'(g)) begin
          r <= d_lo;
        end else if (we_fill && idx_fill == IW'(g)) begin
          r <= d_fill;
        end
      end
      assign q[g*W +: W] = r;
    end
  end
endmodule

// File: rtl/arf_mem_slot.sv
module arf_mem_slot
  import arf_pkg::*;
#(
  parameter int AW   = 18,
  parameter int XW   = 60,
  parameter int N    = 8,
  localparam int IW  = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_store,
  input  logic [IW-1:0] start_idx,
  input  logic [AW-1:0] start_addr,
  input  logic [XW-1:0] start_wdata,
  output logic          busy,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [XW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [XW-1:0] mem_rsp_data,
  output logic          fill_en,
  output logic [IW-1:0] fill_idx,
  output logic [XW-1:0] fill_data,
  output logic [N-1:0]  pend_x
);
  slot_e         state;
  logic          is_store;
  logic [IW-1:0] tgt;
  logic [AW-1:0] addr_q;
  logic [XW-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SL_IDLE;
      is_store <= 1'b0;
      tgt      <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else begin
      case (state)
        SL_IDLE: if (start) begin
          state    <= SL_REQ;
          is_store <= start_store;
          tgt      <= start_idx;
          addr_q   <= start_addr;
          wdata_q  <= start_wdata;
        end
        SL_REQ: if (mem_req_ready) begin
          state <= is_store ? SL_IDLE : SL_WAIT;
        end
        SL_WAIT: if (mem_rsp_valid) begin
          state <= SL_IDLE;
        end
        default: state <= SL_IDLE;
      endcase
    end
  end

  assign busy          = (state != SL_IDLE);
  assign mem_req_valid = (state == SL_REQ);
  assign mem_req_write = is_store;
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = wdata_q;
  assign fill_en       = (state == SL_WAIT) && mem_rsp_valid;
  assign fill_idx      = tgt;
  assign fill_data     = mem_rsp_data;

  for (genvar g = 0; g < N; g++) begin : g_pend
    assign pend_x[g] = busy && !is_store && (tgt == IW'(g));
  end
endmodule

// File: rtl/addr_op_regfile.sv
module addr_op_regfile
  import arf_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 18,
  parameter int XW   = 60,
  localparam int IW  = $clog2(NREG),
  localparam int FIRST_STORE = NREG - 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr0_valid,
  input  logic [1:0]    wr0_kind,
  input  logic [IW-1:0] wr0_idx,
  input  logic [XW-1:0] wr0_data,
  input  logic          wr1_valid,
  input  logic [1:0]    wr1_kind,
  input  logic [IW-1:0] wr1_idx,
  input  logic [XW-1:0] wr1_data,
  output logic          wr_ready,
  input  logic          rd_en,
  input  logic [1:0]    rd_kind,
  input  logic [IW-1:0] rd_idx,
  output logic [XW-1:0] rd_data,
  output logic          rd_stall,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [XW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [XW-1:0] mem_rsp_data
);
  logic [NREG*AW-1:0] a_q;
  logic [NREG*AW-1:0] b_q;
  logic [NREG*XW-1:0] x_q;

  logic          slot_busy;
  logic          fill_en;
  logic [IW-1:0] fill_idx;
  logic [XW-1:0] fill_data;
  logic [NREG-1:0] x_pend;

  logic p0_trig, p1_trig, need_mem, acc0, acc1, start;
  logic [IW-1:0] start_idx;
  logic [AW-1:0] start_addr;

  always_comb begin
    p0_trig  = wr0_valid && (wr0_kind == BANK_A) && (wr0_idx != '0);
    p1_trig  = wr1_valid && (wr1_kind == BANK_A) && (wr1_idx != '0);
    need_mem = p0_trig || p1_trig;
    wr_ready = !slot_busy || !need_mem;
    acc0     = wr0_valid && wr_ready;
    acc1     = wr1_valid && wr_ready;
    start    = wr_ready && need_mem;
    start_idx  = p1_trig ? wr1_idx : wr0_idx;
    start_addr = p1_trig ? wr1_data[AW-1:0] : wr0_data[AW-1:0];
  end

  arf_bank #(.W(AW), .N(NREG), .ZERO_FIRST(1'b0)) u_abank (
    .clk(clk), .rst_n(rst_n),
    .we_hi(acc1 && wr1_kind == BANK_A), .idx_hi(wr1_idx), .d_hi(wr1_data[AW-1:0]),
    .we_lo(acc0 && wr0_kind == BANK_A), .idx_lo(wr0_idx), .d_lo(wr0_data[AW-1:0]),
    .we_fill(1'b0), .idx_fill('0), .d_fill('0),
    .q(a_q)
  );

  arf_bank #(.W(AW), .N(NREG), .ZERO_FIRST(1'b1)) u_bbank (
    .clk(clk), .rst_n(rst_n),
    .we_hi(acc1 && wr1_kind == BANK_B), .idx_hi(wr1_idx), .d_hi(wr1_data[AW-1:0]),
    .we_lo(acc0 && wr0_kind == BANK_B), .idx_lo(wr0_idx), .d_lo(wr0_data[AW-1:0]),
    .we_fill(1'b0), .idx_fill('0), .d_fill('0),
    .q(b_q)
  );

  arf_bank #(.W(XW), .N(NREG), .ZERO_FIRST(1'b0)) u_xbank (
    .clk(clk), .rst_n(rst_n),
    .we_hi(acc1 && wr1_kind == BANK_X), .idx_hi(wr1_idx), .d_hi(wr1_data),
    .we_lo(acc0 && wr0_kind == BANK_X), .idx_lo(wr0_idx), .d_lo(wr0_data),
    .we_fill(fill_en), .idx_fill(fill_idx), .d_fill(fill_data),
    .q(x_q)
  );

  arf_mem_slot #(.AW(AW), .XW(XW), .N(NREG)) u_slot (
    .clk(clk), .rst_n(rst_n),
    .start(start),
    .start_store(int'(start_idx) >= FIRST_STORE),
    .start_idx(start_idx),
    .start_addr(start_addr),
    .start_wdata(x_q[int'(start_idx)*XW +: XW]),
    .busy(slot_busy),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .fill_en(fill_en),
    .fill_idx(fill_idx),
    .fill_data(fill_data),
    .pend_x(x_pend)
  );

  always_comb begin
    case (rd_kind)
      BANK_A:  rd_data = {{(XW-AW){1'b0}}, a_q[int'(rd_idx)*AW +: AW]};
      BANK_B:  rd_data = {{(XW-AW){1'b0}}, b_q[int'(rd_idx)*AW +: AW]};
      BANK_X:  rd_data = x_q[int'(rd_idx)*XW +: XW];
      default: rd_data = '0;
    endcase
    rd_stall = rd_en && (rd_kind == BANK_X) && x_pend[rd_idx];
  end
endmodule

// File: rtl/addr_op_regfile_chk.sv
module addr_op_regfile_chk
  import arf_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 18,
  parameter int XW   = 60,
  localparam int IW  = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr0_valid,
  input logic [1:0]    wr0_kind,
  input logic [IW-1:0] wr0_idx,
  input logic          wr1_valid,
  input logic [1:0]    wr1_kind,
  input logic [IW-1:0] wr1_idx,
  input logic          wr_ready,
  input logic          rd_en,
  input logic [1:0]    rd_kind,
  input logic [IW-1:0] rd_idx,
  input logic [XW-1:0] rd_data,
  input logic          rd_stall,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_write,
  input logic [AW-1:0] mem_req_addr,
  input logic [XW-1:0] mem_req_wdata,
  input logic          mem_rsp_valid,
  input logic [NREG-1:0] x_pend
);
  logic trig_any;
  assign trig_any = (wr0_valid && wr0_kind == BANK_A && wr0_idx != '0) ||
                    (wr1_valid && wr1_kind == BANK_A && wr1_idx != '0);

  AST_SINGLE_LOAD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(x_pend)); // R8

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) &&
      $stable(mem_req_write) && $stable(mem_req_wdata)); // R9

  AST_B0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_kind == BANK_B && rd_idx == '0 |-> rd_data == '0); // R3

  AST_STALL_ONLY_PENDING_X: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stall |-> rd_en && rd_kind == BANK_X && (|x_pend)); // R7

  AST_BLOCK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> trig_any && (mem_req_valid || (|x_pend))); // R8

  AST_REQ_FOLLOWS_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> $past(wr_ready && trig_any)); // R11

  AST_LOAD_MARKS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_write |-> (|x_pend)); // R5

  AST_RSP_ONLY_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> (|x_pend) && !mem_req_valid); // R5
endmodule

bind addr_op_regfile addr_op_regfile_chk #(.NREG(NREG), .AW(AW), .XW(XW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .wr0_valid(wr0_valid), .wr0_kind(wr0_kind), .wr0_idx(wr0_idx),
  .wr1_valid(wr1_valid), .wr1_kind(wr1_kind), .wr1_idx(wr1_idx),
  .wr_ready(wr_ready),
  .rd_en(rd_en), .rd_kind(rd_kind), .rd_idx(rd_idx), .rd_data(rd_data), .rd_stall(rd_stall),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
  .x_pend(x_pend)
);

// File: tb/addr_op_regfile_bench.sv
`timescale 1ns/1ps
module addr_op_regfile_bench;
  import arf_pkg::*;

  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        wr0_valid = 0, wr1_valid = 0;
  logic [1:0]  wr0_kind = 0, wr1_kind = 0;
  logic [2:0]  wr0_idx = 0, wr1_idx = 0;
  logic [59:0] wr0_data = 0, wr1_data = 0;
  logic        wr_ready;
  logic        rd_en = 0;
  logic [1:0]  rd_kind = 0;
  logic [2:0]  rd_idx = 0;
  logic [59:0] rd_data;
  logic        rd_stall;
  logic        mem_req_valid, mem_req_write;
  logic [17:0] mem_req_addr;
  logic [59:0] mem_req_wdata;
  logic        mem_req_ready;
  logic        mem_rsp_valid;
  logic [59:0] mem_rsp_data;

  addr_op_regfile u_addr_op_regfile (
    .clk(clk), .rst_n(rst_n),
    .wr0_valid(wr0_valid), .wr0_kind(wr0_kind), .wr0_idx(wr0_idx), .wr0_data(wr0_data),
    .wr1_valid(wr1_valid), .wr1_kind(wr1_kind), .wr1_idx(wr1_idx), .wr1_data(wr1_data),
    .wr_ready(wr_ready),
    .rd_en(rd_en), .rd_kind(rd_kind), .rd_idx(rd_idx), .rd_data(rd_data), .rd_stall(rd_stall),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  // Behavioural memory: one request at a time, fixed latency.
  logic [59:0] mem_m [0:15];
  int          m_cnt, m_rsp_t, m_reqs;
  logic        m_rsp_pend;
  logic [3:0]  m_rsp_addr;
  logic [17:0] m_last_addr;
  logic        m_last_write;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_req_ready <= 1'b0; mem_rsp_valid <= 1'b0; mem_rsp_data <= '0;
      m_cnt <= 0; m_rsp_t <= 0; m_rsp_pend <= 1'b0; m_reqs <= 0;
      m_rsp_addr <= '0; m_last_addr <= '0; m_last_write <= 1'b0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (m_rsp_pend) begin
        if (m_rsp_t == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= mem_m[m_rsp_addr];
          m_rsp_pend    <= 1'b0;
        end else m_rsp_t <= m_rsp_t - 1;
      end
      if (mem_req_valid && mem_req_ready) begin
        mem_req_ready <= 1'b0; m_cnt <= 0; m_reqs <= m_reqs + 1;
        m_last_addr <= mem_req_addr; m_last_write <= mem_req_write;
        if (mem_req_write) mem_m[mem_req_addr[3:0]] <= mem_req_wdata;
        else begin m_rsp_pend <= 1'b1; m_rsp_t <= LAT; m_rsp_addr <= mem_req_addr[3:0]; end
      end else if (mem_req_valid) begin
        if (m_cnt == LAT) mem_req_ready <= 1'b1;
        else m_cnt <= m_cnt + 1;
      end
    end
  end

  int tests = 0, fails = 0;

  task automatic chk(input string req, input logic [59:0] act, input logic [59:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic put(input int port, input logic [1:0] k, input logic [2:0] i, input logic [59:0] d);
    @(negedge clk);
    if (port == 0) begin wr0_valid = 1; wr0_kind = k; wr0_idx = i; wr0_data = d; end
    else begin wr1_valid = 1; wr1_kind = k; wr1_idx = i; wr1_data = d; end
    #1;
    for (int w = 0; w < 200 && !wr_ready; w++) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    wr0_valid = 0; wr1_valid = 0;
  endtask

  task automatic rd(input logic [1:0] k, input logic [2:0] i, output logic [59:0] d, output logic s);
    @(negedge clk);
    rd_en = 1; rd_kind = k; rd_idx = i;
    #1;
    d = rd_data; s = rd_stall;
    rd_en = 0;
  endtask

  task automatic wait_idle();
    for (int w = 0; w < 100; w++) begin
      @(negedge clk); #1;
      if (!mem_req_valid && !m_rsp_pend && !mem_rsp_valid) break;
    end
  endtask

  localparam int NV = 8;
  localparam logic [1:0]  VK [NV] = '{BANK_B, BANK_B, BANK_X, BANK_X, BANK_A, BANK_B, BANK_X, BANK_B};
  localparam logic [2:0]  VI [NV] = '{3'd3, 3'd0, 3'd0, 3'd7, 3'd0, 3'd7, 3'd3, 3'd5};
  localparam logic [59:0] VD [NV] = '{60'hFFFFFFFFFFFFFFF, 60'h123, 60'hABCDE123456789A,
                                      60'h800000000000001, 60'h543210ABC, 60'h2AAAA,
                                      60'hFFFFFFFFFFFFFFF, 60'h15};
  localparam logic [59:0] VE [NV] = '{60'h3FFFF, 60'h0, 60'hABCDE123456789A,
                                      60'h800000000000001, 60'h10ABC, 60'h2AAAA,
                                      60'hFFFFFFFFFFFFFFF, 60'h15};

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [59:0] d;
    logic s;
    int reqs0;
    for (int m = 0; m < 16; m++) mem_m[m] = 60'(m) * 60'h111;
    mem_m[5] = 60'h123456789ABCDEF;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    rd(BANK_A, 3'd3, d, s); chk("R1 A3", d, 0);
    rd(BANK_X, 3'd1, d, s); chk("R1 X1", d, 0); chk("R1 stall", 60'(s), 0);
    chk("R1 wr_ready", 60'(wr_ready), 1);
    chk("R1 req_valid", 60'(mem_req_valid), 0);

    // R2 / R3 table walk
    for (int v = 0; v < NV; v++) begin
      put(0, VK[v], VI[v], VD[v]);
      rd(VK[v], VI[v], d, s);
      chk((VK[v] == BANK_B && VI[v] == 0) ? "R3 B0" : "R2 table", d, VE[v]);
    end
    rd(BANK_NONE, 3'd3, d, s); chk("R2 kind3", d, 0);

    // R4 A0 scratch
    reqs0 = m_reqs;
    put(0, BANK_A, 3'd0, 60'h7);
    repeat (6) @(negedge clk);
    chk("R4 no request", 60'(m_reqs), 60'(reqs0));
    chk("R4 no valid", 60'(mem_req_valid), 0);
    rd(BANK_A, 3'd0, d, s); chk("R4 A0 value", d, 60'h7);

    // R5/R7/R8/R9/R11 load through A2
    put(0, BANK_A, 3'd2, 60'h5);
    rd(BANK_X, 3'd2, d, s);
    chk("R11 req next cycle", 60'(mem_req_valid), 1);
    chk("R5 load dir", 60'(mem_req_write), 0);
    chk("R5 load addr", 60'(mem_req_addr), 60'h5);
    chk("R7 stall pending", 60'(s), 1);
    @(negedge clk);
    wr0_valid = 1; wr0_kind = BANK_A; wr0_idx = 3'd3; wr0_data = 60'h9;
    #1;
    chk("R8 blocked", 60'(wr_ready), 0);
    chk("R9 held valid", 60'(mem_req_valid), 1);
    chk("R9 held addr", 60'(mem_req_addr), 60'h5);
    wr0_valid = 0;
    put(0, BANK_B, 3'd1, 60'h321);
    wait_idle();
    rd(BANK_X, 3'd2, d, s);
    chk("R5 fill data", d, 60'h123456789ABCDEF);
    chk("R7 stall cleared", 60'(s), 0);
    chk("R8 one request", 60'(m_reqs), 60'(reqs0 + 1));
    rd(BANK_B, 3'd1, d, s); chk("R8 other write ok", d, 60'h321);
    rd(BANK_A, 3'd3, d, s); chk("R8 A3 untouched", d, 0);

    // R6 store through A6, X changed right after
    put(0, BANK_X, 3'd6, 60'hCAFE0000BEEF001);
    put(0, BANK_A, 3'd6, 60'h9);
    put(0, BANK_X, 3'd6, 60'h0DD0000000000F0);
    wait_idle();
    chk("R6 store dir", 60'(m_last_write), 1);
    chk("R6 store addr", 60'(m_last_addr), 60'h9);
    chk("R6 store data", mem_m[9], 60'hCAFE0000BEEF001);
    rd(BANK_X, 3'd6, d, s); chk("R6 X6 later value", d, 60'h0DD0000000000F0);

    // R10 collision between ports
    @(negedge clk);
    wr0_valid = 1; wr0_kind = BANK_X; wr0_idx = 3'd4; wr0_data = 60'hAAA;
    wr1_valid = 1; wr1_kind = BANK_X; wr1_idx = 3'd4; wr1_data = 60'hBBB;
    @(posedge clk); #1;
    wr0_kind = BANK_B; wr0_idx = 3'd2; wr0_data = 60'h111;
    wr1_kind = BANK_B; wr1_idx = 3'd2; wr1_data = 60'h222;
    @(posedge clk); #1;
    wr0_valid = 0; wr1_valid = 0;
    rd(BANK_X, 3'd4, d, s); chk("R10 X4 port1", d, 60'hBBB);
    rd(BANK_B, 3'd2, d, s); chk("R10 B2 port1", d, 60'h222);

    finish_run();
  end
endmodule